// File: doc/BRIEF.md
# Accumulator ALU Execute Unit

This block is the execute stage of a small 32-bit accumulator machine whose instructions are 16 bits wide: an 8-bit opcode and an 8-bit operand field. Each cycle the decoder presents the following to this unit:

- an issue strobe;
- the opcode;
- the raw 8-bit immediate;
- the register-file value selected by the operand field.

The unit holds the accumulator. It computes the next accumulator value for arithmetic, logic, shift and load operations, and raises a write-enable when the opcode is one it handles.

Immediate extension depends on the operation. Arithmetic immediates and the plain immediate load are sign-extended. Logic immediates are zero-extended. The right shift is arithmetic and shifts by one position. Three byte-insertion loads place the immediate into byte 1, 2 or 3 of the accumulator. Each of them sign-extends that byte upward and keeps the bytes below. A loadi followed by the three insertion loads, in ascending byte order, therefore builds any 32-bit constant.

Top module: `acc_exec_unit`

## Requirements
- R1: A high `rst` at a rising edge of `clk` sets `acc` to 0 at that edge, whatever `issue` and `opcode` carry.
- R2: Opcodes matching `000010?b` add and opcodes matching `000011?b` subtract. Bit 0 set selects the immediate, sign-extended from 8 to 32 bits; bit 0 clear selects `reg_val`. Results wrap modulo 2^32.
- R3: Opcodes `0x22`/`0x23` AND, `0x24`/`0x25` OR and `0x26`/`0x27` XOR the accumulator with `reg_val` (even code) or with the zero-extended immediate (odd code).
- R4: Opcodes matching `00010???` shift the accumulator right by one position and keep bit 31 unchanged.
- R5: Opcode `0x20` copies `reg_val` into the accumulator. Opcode `0x21` loads the sign-extended immediate.
- R6: Opcodes `0x29`, `0x2A` and `0x2B` write the immediate into byte 1, 2 or 3 of the accumulator. They fill every higher byte with copies of the immediate's bit 7 and leave every lower byte unchanged.
- R7: Opcodes matching `00000???` (nop) and every opcode not listed in R2–R6 hold `acc` and keep `acc_we` low.
- R8: `acc_we` is high in the same cycle as `issue` is high with an opcode from R2–R6, and is low otherwise. `acc` takes its new value at the next rising edge only when `acc_we` is high.
- R9: The sequence `0x21`, `0x29`, `0x2A`, `0x2B`, with immediates b0, b1, b2, b3, leaves `acc` equal to {b3,b2,b1,b0}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| issue | input | 1 | An instruction is present this cycle |
| opcode | input | 8 | Decoded opcode byte |
| imm | input | 8 | Raw operand byte used as immediate |
| reg_val | input | 32 | Register-file value for register forms |
| acc | output | 32 | Current accumulator |
| acc_we | output | 1 | Accumulator write-enable for this cycle |

## Verification
`acc_we` is combinational, so it is due in the cycle the instruction is presented. The bench samples it 1 ns after the falling edge at which the inputs were driven. The new `acc` is due one register later, so it is sampled 1 ns after the following rising edge. Before every swept vector the accumulator is first preloaded through opcode `0x20`, so that the prior state is known when the expected value is computed. The sweep covers all 256 opcodes against several immediates and accumulator values, and constant-building sequences cover R9.

// File: rtl/acc_exec_unit.sv
`timescale 1ns/1ps
module acc_exec_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic [7:0]      opcode,
  input  logic [7:0]      imm,
  input  logic [XLEN-1:0] reg_val,
  output logic [XLEN-1:0] acc,
  output logic            acc_we
);

  logic [XLEN-1:0] imm_s, imm_z, rhs, nxt;
  logic            hit;

  assign imm_s = {{(XLEN-8){imm[7]}}, imm};
  assign imm_z = {{(XLEN-8){1'b0}}, imm};

  always_comb begin
    hit = 1'b1;
    nxt = acc;
    rhs = opcode[0] ? imm_s : reg_val;
    casez (opcode)
      8'b000010??: nxt = acc + rhs;
      8'b000011??: nxt = acc - rhs;
      8'b00010???: nxt = {acc[XLEN-1], acc[XLEN-1:1]};
      8'b00100000: nxt = reg_val;
      8'b00100001: nxt = imm_s;
      8'b00100010: nxt = acc & reg_val;
      8'b00100011: nxt = acc & imm_z;
      8'b00100100: nxt = acc | reg_val;
      8'b00100101: nxt = acc | imm_z;
      8'b00100110: nxt = acc ^ reg_val;
      8'b00100111: nxt = acc ^ imm_z;
      8'b00101001: nxt = {imm_s[XLEN-9:0],  acc[7:0]};
      8'b00101010: nxt = {imm_s[XLEN-17:0], acc[15:0]};
      8'b00101011: nxt = {imm_s[XLEN-25:0], acc[23:0]};
      default:     hit = 1'b0;
    endcase
  end

  assign acc_we = issue & hit;

  always_ff @(posedge clk) begin
    if (rst)         acc <= '0;
    else if (acc_we) acc <= nxt;
  end

endmodule

// File: rtl/acc_exec_chk.sv
`timescale 1ns/1ps
module acc_exec_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            issue,
  input logic [7:0]      opcode,
  input logic [7:0]      imm,
  input logic [XLEN-1:0] acc,
  input logic            acc_we
);

  // R7
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode[7:3] == 5'b00000) |-> !acc_we);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !issue |-> !acc_we);

  // R8
  hold_acc_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_we |=> acc == $past(acc));

  // R4
  shr_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && opcode[7:3] == 5'b00010) |=>
      (acc[XLEN-1] == $past(acc[XLEN-1])) && (acc[XLEN-2:0] == $past(acc[XLEN-1:1])));

  // R5
  loadi_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && opcode == 8'h21) |=>
      acc == {{(XLEN-8){$past(imm[7])}}, $past(imm)});

  // R3
  andi_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && opcode == 8'h23) |=> acc[XLEN-1:8] == '0);

  // R6
  top_byte_ins_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && opcode == 8'h2B) |=>
      (acc[31:24] == $past(imm)) && (acc[23:0] == $past(acc[23:0])));

  // R2
  addi_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && opcode[7:2] == 6'b000010 && opcode[0]) |=>
      acc == $past(acc) + {{(XLEN-8){$past(imm[7])}}, $past(imm)});

endmodule

bind acc_exec_unit acc_exec_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .issue(issue), .opcode(opcode),
  .imm(imm), .acc(acc), .acc_we(acc_we)
);

// File: tb/sim_acc_exec_unit.sv
`timescale 1ns/1ps
module sim_acc_exec_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  imm = 8'h00;
  logic [31:0] reg_val = 32'h0;
  logic [31:0] acc;
  logic        acc_we;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acc_exec_unit u0 (
    .clk(clk), .rst(rst), .issue(issue), .opcode(opcode),
    .imm(imm), .reg_val(reg_val), .acc(acc), .acc_we(acc_we)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%02h imm=%02h got=%08h exp=%08h", req, opcode, imm, got, exp);
    end
  endtask

  function automatic string tag(input logic [7:0] op);
    if (op[7:3] == 5'b00001) return "R2";
    if (op[7:3] == 5'b00010) return "R4";
    if (op == 8'h20 || op == 8'h21) return "R5";
    if (op >= 8'h22 && op <= 8'h27) return "R3";
    if (op >= 8'h29 && op <= 8'h2B) return "R6";
    return "R7";
  endfunction

  // expected behaviour computed arithmetically from the requirements
  task automatic model(input logic [7:0] op, input logic [7:0] im, input logic [31:0] rv,
                       input logic [31:0] a, output logic we, output logic [31:0] nx);
    longint sx, sa, opnd, r;
    sx = (im >= 8'd128) ? longint'(im) - 256 : longint'(im);
    sa = a[31] ? longint'(a) - 64'sd4294967296 : longint'(a);
    we = 1'b1;
    nx = a;
    if (op[7:3] == 5'b00001) begin
      opnd = op[0] ? sx : longint'(rv);
      r = op[2] ? longint'(a) - opnd : longint'(a) + opnd;
      nx = r[31:0];
    end else if (op[7:3] == 5'b00010) begin
      r = (sa - (sa < 0 ? 1 : 0)) / 2;
      nx = r[31:0];
    end else if (op == 8'h20) nx = rv;
    else if (op == 8'h21) begin r = sx; nx = r[31:0]; end
    else if (op == 8'h22) nx = a & rv;
    else if (op == 8'h23) nx = a & {24'h0, im};
    else if (op == 8'h24) nx = a | rv;
    else if (op == 8'h25) nx = a | {24'h0, im};
    else if (op == 8'h26) nx = a ^ rv;
    else if (op == 8'h27) nx = a ^ {24'h0, im};
    else if (op >= 8'h29 && op <= 8'h2B) begin
      longint w;
      w = longint'(1) << (8 * (op - 8'h28));
      r = (longint'(a) % w) + sx * w;
      nx = r[31:0];
    end else we = 1'b0;
  endtask

  task automatic apply(input logic iss, input logic [7:0] op, input logic [7:0] im,
                       input logic [31:0] rv);
    @(negedge clk);
    issue = iss; opcode = op; imm = im; reg_val = rv;
  endtask

  task automatic preload(input logic [31:0] v);
    apply(1'b1, 8'h20, 8'h00, v);
    @(posedge clk); #1;
  endtask

  task automatic build(input logic [31:0] k);
    apply(1'b1, 8'h21, k[7:0], 32'h0);   @(posedge clk);
    apply(1'b1, 8'h29, k[15:8], 32'h0);  @(posedge clk);
    apply(1'b1, 8'h2A, k[23:16], 32'h0); @(posedge clk);
    apply(1'b1, 8'h2B, k[31:24], 32'h0); @(posedge clk); #1;
    check("R9", acc, k);
  endtask

  initial begin
    logic [31:0] seeds [5] = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hDEAD_BEEF, 32'hFFFF_FFFF};
    logic [7:0]  imms  [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'hA5};
    logic        we_e;
    logic [31:0] nx_e;

    repeat (2) @(posedge clk);
    #1 check("R1", acc, 32'h0);
    @(negedge clk); rst = 1'b0;

    // reset wins over a valid instruction
    preload(32'h1234_5678);
    check("R5", acc, 32'h1234_5678);
    apply(1'b1, 8'h21, 8'h55, 32'h0); rst = 1'b1;
    @(posedge clk); #1 check("R1", acc, 32'h0);
    @(negedge clk); rst = 1'b0;

    // no issue: valid opcode has no effect
    preload(32'hCAFE_0001);
    apply(1'b0, 8'h21, 8'h7F, 32'h0);
    #1 check("R8", {31'h0, acc_we}, 32'h0);
    @(posedge clk); #1 check("R8", acc, 32'hCAFE_0001);

    // sweep every opcode
    for (int o = 0; o < 256; o++)
      for (int s = 0; s < 5; s++)
        for (int i = 0; i < 6; i++) begin
          logic [31:0] rv;
          rv = seeds[(s + i) % 5] ^ {imms[i], 24'h00_3C_C3};
          preload(seeds[s]);
          model(8'(o), imms[i], rv, seeds[s], we_e, nx_e);
          apply(1'b1, 8'(o), imms[i], rv);
          #1 check("R8", {31'h0, acc_we}, {31'h0, we_e});
          @(posedge clk); #1 check(tag(8'(o)), acc, nx_e);
        end

    build(32'hDEAD_BEEF);
    build(32'h0000_0080);
    build(32'h7F80_FF00);
    build(32'hFFFF_FFFF);
    build(32'h8000_007F);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule